// File: doc/BRIEF.md
# Masked Packed Double-to-Int32 Narrowing Unit

This block turns a vector of up to eight IEEE-754 binary64 values into signed 32-bit integers. Results are packed side by side in the low half of a 512-bit destination. Lane j reads source bits [64j+63:64j] and writes destination bits [32j+31:32j]. A per-lane write mask picks, lane by lane, whether the converted value lands. A lane that is not written either keeps the prior destination bits (merge) or is cleared (zero). The block also handles broadcast of the lowest source element, an embedded rounding override, and the rules for which destination bits are cleared or kept above the packed results.

The caller presents the operands together with a one-cycle `in_valid` strobe. The new destination and the exception flags appear registered one cycle later with `out_valid`. The flags are the OR of the invalid and inexact flags of the lanes actually written. A register-specifier field other than all ones raises `ud_fault`. In that case nothing is written: the old destination is returned unchanged.

Top module: `pk2dq_conv`

## Requirements
- R1: `vl_sel` sets the lane count: 2'b00 gives 2 lanes, 2'b01 gives 4, and 2'b10 or 2'b11 gives 8. With `legacy` = 1 the count is always 2.
- R2: Lane j converts `src_vec[64j+63:64j]` and places the two's-complement INT32 result in `dst_out[32j+31:32j]`.
- R3: Rounding mode codes are 2'b00 to nearest with ties to even, 2'b01 toward minus infinity, 2'b10 toward plus infinity and 2'b11 toward zero. A lane whose value is not exactly representable raises inexact.
- R4: NaN, infinity and any value whose rounded result falls outside [-2^31, 2^31-1] yield 32'h80000000 with invalid set and inexact clear for that lane.
- R5: With `mask_en` = 1 and `legacy` = 0, lane j is written only if `lane_mask[j]` = 1. An unwritten lane keeps `old_dst` bits when `zero_mode` = 0 and becomes 0 when `zero_mode` = 1. Mask bits at or above the lane count have no effect.
- R6: With `mem_src` = 1, `bcast` = 1 and `legacy` = 0, every written lane converts `src_vec[63:0]`. With `mem_src` = 0, no lane is broadcast.
- R7: `emb_rc` replaces `glob_rc` only when `vl_sel[1]` = 1, `mem_src` = 0, `bcast` = 1 and `legacy` = 0. In every other case `glob_rc` is used.
- R8: With `legacy` = 0, every destination bit from 32 × lane count upward is 0.
- R9: With `legacy` = 1, both lanes are always written, whatever the mask. Bits [127:64] are 0 and bits [511:128] equal `old_dst`.
- R10: If `reg_spec` is not 4'b1111, `ud_fault` is 1, `dst_out` equals `old_dst` and `flags_out` is 0.
- R11: `flags_out` is {inexact, invalid}, with invalid at bit 0. Each flag is the OR of that flag over the lanes that were written.
- R12: Outputs are registered. `out_valid` follows `in_valid` by one cycle, and the other outputs hold when `in_valid` is 0. Reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands valid this cycle |
| src_vec | input | 512 | Eight binary64 source lanes |
| old_dst | input | 512 | Prior destination value |
| lane_mask | input | 8 | Per-lane write enables |
| mask_en | input | 1 | 1: apply lane_mask |
| zero_mode | input | 1 | 1: clear unwritten lanes, 0: keep old bits |
| vl_sel | input | 2 | Vector length code |
| bcast | input | 1 | Broadcast / rounding-override bit |
| mem_src | input | 1 | 1: source came from memory |
| emb_rc | input | 2 | Per-operation rounding mode |
| glob_rc | input | 2 | Global rounding mode |
| legacy | input | 1 | 1: legacy 128-bit form |
| reg_spec | input | 4 | Extra register specifier, must be 4'b1111 |
| out_valid | output | 1 | Result valid |
| dst_out | output | 512 | New destination |
| flags_out | output | 2 | {inexact, invalid} |
| ud_fault | output | 1 | Undefined-opcode fault |

## Verification
The scalar path is driven through all eight lanes at once using a table of binary64 values. The table includes exact integers, halfway cases of both signs, denormals, signed zero, NaN, infinity and values just inside and just outside the INT32 range. Each value is paired with a rounding mode, so the four modes can be told apart on the same inputs. Directed cases use a distinct integer per lane, which exposes lane swaps, wrong lane counts and leaks into cleared regions. Sparse masks under merge and zero, broadcast from memory versus register, override-eligible versus ineligible lengths, the legacy form, and a bad specifier each separate one control path from the others.

// File: rtl/pk2dq_pkg.sv
package pk2dq_pkg;

  localparam int unsigned SRC_LANE_W = 64;
  localparam int unsigned DST_LANE_W = 32;

  typedef enum logic [1:0] {
    RND_NEAR = 2'b00,
    RND_DOWN = 2'b01,
    RND_UP   = 2'b10,
    RND_ZERO = 2'b11
  } rnd_mode_e;

  typedef enum logic [1:0] {
    SEL_ZERO = 2'b00,
    SEL_OLD  = 2'b01,
    SEL_CONV = 2'b10
  } slot_sel_e;

  typedef struct packed {
    logic inexact;
    logic invalid;
  } cvt_flags_t;

endpackage

// File: rtl/pk2dq_f2i.sv
module pk2dq_f2i
  import pk2dq_pkg::*;
(
  input  logic [SRC_LANE_W-1:0] fp_in,
  input  rnd_mode_e             rnd,
  output logic [DST_LANE_W-1:0] int_out,
  output cvt_flags_t            flg
);

  localparam int unsigned FRAC_W = 52;
  localparam int unsigned EXP_W  = 11;
  localparam int unsigned SIG_W  = FRAC_W + 1;
  localparam int unsigned FIX_W  = 64;
  localparam int unsigned WIDE_W = SIG_W + FIX_W;
  localparam int unsigned MAG_W  = SIG_W + 1;
  localparam logic signed [EXP_W+1:0] BIAS = 13'sd1023;
  localparam logic [MAG_W-1:0] POS_MAX = MAG_W'(64'h7FFF_FFFF);
  localparam logic [MAG_W-1:0] NEG_MAX = MAG_W'(64'h8000_0000);

  logic                     sgn;
  logic [EXP_W-1:0]         ex_raw;
  logic [FRAC_W-1:0]        frac;
  logic signed [EXP_W+1:0]  ex_unb;
  logic [SIG_W-1:0]         sig;
  logic [WIDE_W-1:0]        shifted;
  logic [6:0]               sh;
  logic                     special, tiny, huge;
  logic [SIG_W-1:0]         ipart;
  logic                     grd, stk, bump, fits;
  logic [MAG_W-1:0]         mag;

  always_comb begin
    sgn     = fp_in[63];
    ex_raw  = fp_in[62:52];
    frac    = fp_in[51:0];
    special = &ex_raw;
    sig     = {|ex_raw, frac};
    ex_unb  = $signed({2'b00, ex_raw}) - BIAS;
    tiny    = ex_unb < -13'sd1;
    huge    = ex_unb > 13'sd32;
    // right shift that leaves the binary point at bit FIX_W
    sh      = 7'd52 - ex_unb[6:0];
    shifted = {sig, {FIX_W{1'b0}}} >> sh;

    if (tiny) begin
      ipart = '0;
      grd   = 1'b0;
      stk   = |fp_in[62:0];
    end else begin
      ipart = shifted[WIDE_W-1:FIX_W];
      grd   = shifted[FIX_W-1];
      stk   = |shifted[FIX_W-2:0];
    end

    case (rnd)
      RND_NEAR: bump = grd & (stk | ipart[0]);
      RND_DOWN: bump = sgn & (grd | stk);
      RND_UP:   bump = ~sgn & (grd | stk);
      default:  bump = 1'b0;
    endcase

    mag  = {1'b0, ipart} + MAG_W'(bump);
    fits = sgn ? (mag <= NEG_MAX) : (mag <= POS_MAX);

    if (special || huge || !fits) begin
      int_out     = 32'h8000_0000;
      flg.invalid = 1'b1;
      flg.inexact = 1'b0;
    end else begin
      int_out     = sgn ? (~mag[31:0] + 32'd1) : mag[31:0];
      flg.invalid = 1'b0;
      flg.inexact = grd | stk;
    end
  end

  // R4: an invalid lane never also reports inexact and always returns the indefinite code
  always_comb begin
    a_r4_one_flag: assert (!(flg.invalid && flg.inexact));
    if (flg.invalid) begin
      a_r4_indef_code: assert (int_out == 32'h8000_0000);
    end
  end

endmodule

// File: rtl/pk2dq_lane.sv
module pk2dq_lane
  import pk2dq_pkg::*;
(
  input  logic [SRC_LANE_W-1:0] own_src,
  input  logic [SRC_LANE_W-1:0] first_src,
  input  logic                  bcast_src,
  input  rnd_mode_e             rnd,
  output logic [DST_LANE_W-1:0] res,
  output cvt_flags_t            flg
);

  logic [SRC_LANE_W-1:0] pick;

  assign pick = bcast_src ? first_src : own_src;

  pk2dq_f2i u_cvt (
    .fp_in   (pick),
    .rnd     (rnd),
    .int_out (res),
    .flg     (flg)
  );

endmodule

// File: rtl/pk2dq_ctl.sv
module pk2dq_ctl
  import pk2dq_pkg::*;
#(
  parameter int unsigned N_LANES = 8
) (
  input  logic [1:0]               vl_sel,
  input  logic                     legacy,
  input  logic                     mask_en,
  input  logic [N_LANES-1:0]       lane_mask,
  input  logic                     zero_mode,
  input  logic                     bcast,
  input  logic                     mem_src,
  input  rnd_mode_e                emb_rc,
  input  rnd_mode_e                glob_rc,
  input  logic [3:0]               reg_spec,
  output slot_sel_e [2*N_LANES-1:0] slot_sel,
  output rnd_mode_e                rnd,
  output logic                     bcast_src,
  output logic                     fault
);

  localparam int unsigned N_SLOTS  = 2 * N_LANES;
  localparam int unsigned CNT_W    = $clog2(N_SLOTS + 1);
  localparam int          LEG_KEEP = 128 / DST_LANE_W;
  localparam logic [3:0]  SPEC_OK  = 4'hF;

  logic [CNT_W-1:0]   span_raw, span;
  logic [N_LANES-1:0] lane_on;

  always_comb begin
    fault = (reg_spec != SPEC_OK);

    case (vl_sel)
      2'b00:   span_raw = CNT_W'(2);
      2'b01:   span_raw = CNT_W'(4);
      default: span_raw = CNT_W'(8);
    endcase
    if (legacy) span_raw = CNT_W'(2);
    span = (span_raw > CNT_W'(N_LANES)) ? CNT_W'(N_LANES) : span_raw;

    bcast_src = mem_src & bcast & ~legacy;
    rnd       = (bcast & ~mem_src & ~legacy & vl_sel[1]) ? emb_rc : glob_rc;

    for (int j = 0; j < N_LANES; j++) begin
      lane_on[j] = legacy | ~mask_en | lane_mask[j];
    end

    for (int k = 0; k < N_SLOTS; k++) begin
      if (fault) begin
        slot_sel[k] = SEL_OLD;
      end else if (CNT_W'(k) < span) begin
        if (lane_on[k % N_LANES]) slot_sel[k] = SEL_CONV;
        else if (zero_mode)       slot_sel[k] = SEL_ZERO;
        else                      slot_sel[k] = SEL_OLD;
      end else if (legacy && (k >= LEG_KEEP)) begin
        slot_sel[k] = SEL_OLD;
      end else begin
        slot_sel[k] = SEL_ZERO;
      end
    end
  end

endmodule

// File: rtl/pk2dq_conv.sv
module pk2dq_conv
  import pk2dq_pkg::*;
#(
  parameter int unsigned N_LANES = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic [N_LANES*SRC_LANE_W-1:0] src_vec,
  input  logic [N_LANES*SRC_LANE_W-1:0] old_dst,
  input  logic [N_LANES-1:0]            lane_mask,
  input  logic                          mask_en,
  input  logic                          zero_mode,
  input  logic [1:0]                    vl_sel,
  input  logic                          bcast,
  input  logic                          mem_src,
  input  logic [1:0]                    emb_rc,
  input  logic [1:0]                    glob_rc,
  input  logic                          legacy,
  input  logic [3:0]                    reg_spec,
  output logic                          out_valid,
  output logic [N_LANES*SRC_LANE_W-1:0] dst_out,
  output logic [1:0]                    flags_out,
  output logic                          ud_fault
);

  localparam int unsigned VEC_W   = N_LANES * SRC_LANE_W;
  localparam int unsigned N_SLOTS = VEC_W / DST_LANE_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  slot_sel_e [N_SLOTS-1:0]                 slot_sel;
  rnd_mode_e                               rnd;
  logic                                    bcast_src, fault_d;
  logic [N_LANES-1:0][DST_LANE_W-1:0]      lane_res;
  cvt_flags_t [N_LANES-1:0]                lane_flg;
  logic [N_SLOTS-1:0][DST_LANE_W-1:0]      slot_val;
  logic [VEC_W-1:0]                        dst_d;
  cvt_flags_t                              flg_d;

  pk2dq_ctl #(.N_LANES(N_LANES)) u_ctl (
    .vl_sel    (vl_sel),
    .legacy    (legacy),
    .mask_en   (mask_en),
    .lane_mask (lane_mask),
    .zero_mode (zero_mode),
    .bcast     (bcast),
    .mem_src   (mem_src),
    .emb_rc    (rnd_mode_e'(emb_rc)),
    .glob_rc   (rnd_mode_e'(glob_rc)),
    .reg_spec  (reg_spec),
    .slot_sel  (slot_sel),
    .rnd       (rnd),
    .bcast_src (bcast_src),
    .fault     (fault_d)
  );

  for (genvar j = 0; j < N_LANES; j++) begin : g_lane
    pk2dq_lane u_lane (
      .own_src   (src_vec[j*SRC_LANE_W +: SRC_LANE_W]),
      .first_src (src_vec[SRC_LANE_W-1:0]),
      .bcast_src (bcast_src),
      .rnd       (rnd),
      .res       (lane_res[j]),
      .flg       (lane_flg[j])
    );
  end

  for (genvar k = 0; k < N_SLOTS; k++) begin : g_slot
    if (k < N_LANES) begin : g_conv
      assign slot_val[k] = (slot_sel[k] == SEL_CONV) ? lane_res[k] :
                           (slot_sel[k] == SEL_OLD)  ? old_dst[k*DST_LANE_W +: DST_LANE_W] :
                                                       '0;
    end else begin : g_fill
      assign slot_val[k] = (slot_sel[k] == SEL_OLD) ? old_dst[k*DST_LANE_W +: DST_LANE_W] : '0;
    end
  end

  assign dst_d = slot_val;

  always_comb begin
    flg_d = '0;
    for (int j = 0; j < N_LANES; j++) begin
      if (slot_sel[j] == SEL_CONV) flg_d = flg_d | lane_flg[j];
    end
  end

  logic             out_valid_q, fault_q;
  logic [VEC_W-1:0] dst_q;
  cvt_flags_t       flags_q;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      out_valid_q <= 1'b0;
      dst_q       <= '0;
      flags_q     <= '0;
      fault_q     <= 1'b0;
    end else begin
      out_valid_q <= in_valid;
      if (in_valid) begin
        dst_q   <= dst_d;
        flags_q <= flg_d;
        fault_q <= fault_d;
      end
    end
  end

  assign out_valid = out_valid_q;
  assign dst_out   = dst_q;
  assign flags_out = flags_q;
  assign ud_fault  = fault_q;

  // ---------------- assertions ----------------
  a_r10_fault_keeps_old: assert property (@(posedge clk) disable iff (!rst_sn)
    (in_valid && reg_spec != 4'hF) |=>
      (fault_q && dst_q == $past(old_dst) && flags_q == '0));

  a_r9_legacy_upper: assert property (@(posedge clk) disable iff (!rst_sn)
    (in_valid && legacy && reg_spec == 4'hF) |=>
      (dst_q[VEC_W-1:128] == $past(old_dst[VEC_W-1:128]) && dst_q[127:64] == '0));

  a_r8_short_upper_zero: assert property (@(posedge clk) disable iff (!rst_sn)
    (in_valid && !legacy && reg_spec == 4'hF && vl_sel == 2'b00) |=>
      (dst_q[VEC_W-1:64] == '0));

  a_r12_valid_follows: assert property (@(posedge clk) disable iff (!rst_sn)
    1'b1 |=> (out_valid_q == $past(in_valid)));

  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_sn)
    !in_valid |=> ($stable(dst_q) && $stable(flags_q) && $stable(fault_q)));

endmodule

// File: tb/sim_pk2dq_conv.sv
module sim_pk2dq_conv;

  localparam int VEC_W = 512;
  localparam logic [VEC_W-1:0] OLDPAT = {16{32'hC0DE_F00D}};
  localparam logic [63:0] D_NAN  = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] D_2P5  = 64'h4004_0000_0000_0000;

  // {binary64 in, rounding code, expected int32, expected {inexact, invalid}}
  localparam int N_TBL = 24;
  localparam logic [99:0] TBL [N_TBL] = '{
    {64'h3FF0000000000000, 2'b00, 32'h00000001, 2'b00},
    {64'h4004000000000000, 2'b00, 32'h00000002, 2'b10},
    {64'h4004000000000000, 2'b01, 32'h00000002, 2'b10},
    {64'h4004000000000000, 2'b10, 32'h00000003, 2'b10},
    {64'hC004000000000000, 2'b00, 32'hFFFFFFFE, 2'b10},
    {64'hC004000000000000, 2'b01, 32'hFFFFFFFD, 2'b10},
    {64'hC004000000000000, 2'b11, 32'hFFFFFFFE, 2'b10},
    {64'h400C000000000000, 2'b00, 32'h00000004, 2'b10},
    {64'h8000000000000000, 2'b00, 32'h00000000, 2'b00},
    {64'h41E0000000000000, 2'b11, 32'h80000000, 2'b01},
    {64'hC1E0000000000000, 2'b00, 32'h80000000, 2'b00},
    {64'h41DFFFFFFFC00000, 2'b00, 32'h7FFFFFFF, 2'b00},
    {64'h41DFFFFFFFE00000, 2'b00, 32'h80000000, 2'b01},
    {64'h41DFFFFFFFE00000, 2'b11, 32'h7FFFFFFF, 2'b10},
    {64'hC1E0000000100000, 2'b00, 32'h80000000, 2'b10},
    {64'hC1E0000000100000, 2'b01, 32'h80000000, 2'b01},
    {64'h7FF8000000000000, 2'b00, 32'h80000000, 2'b01},
    {64'hFFF0000000000000, 2'b10, 32'h80000000, 2'b01},
    {64'h0000000000000001, 2'b10, 32'h00000001, 2'b10},
    {64'h8000000000000001, 2'b01, 32'hFFFFFFFF, 2'b10},
    {64'h3FE0000000000000, 2'b00, 32'h00000000, 2'b10},
    {64'h4059300000000000, 2'b00, 32'h00000065, 2'b10},
    {64'h4202A05F20000000, 2'b00, 32'h80000000, 2'b01},
    {64'hBFF0000000000000, 2'b11, 32'hFFFFFFFF, 2'b00}
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst_n, in_valid, mask_en, zero_mode, bcast, mem_src, legacy;
  logic [VEC_W-1:0] src_vec, old_dst;
  logic [7:0]       lane_mask;
  logic [1:0]       vl_sel, emb_rc, glob_rc;
  logic [3:0]       reg_spec;
  logic             out_valid, ud_fault;
  logic [VEC_W-1:0] dst_out;
  logic [1:0]       flags_out;

  pk2dq_conv u0 (
    .clk, .rst_n, .in_valid, .src_vec, .old_dst, .lane_mask, .mask_en, .zero_mode,
    .vl_sel, .bcast, .mem_src, .emb_rc, .glob_rc, .legacy, .reg_spec,
    .out_valid, .dst_out, .flags_out, .ud_fault
  );

  int n_chk = 0;
  int n_err = 0;

  task automatic check(input string tag, input logic [VEC_W-1:0] act, input logic [VEC_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] dbl(input int unsigned n);
    int msb;
    logic [63:0] wm;
    msb = 0;
    for (int b = 0; b < 32; b++) if (n[b]) msb = b;
    wm = 64'(n) << (52 - msb);
    return {1'b0, 11'(1023 + msb), wm[51:0]};
  endfunction

  function automatic logic [VEC_W-1:0] ramp();
    logic [VEC_W-1:0] v;
    for (int j = 0; j < 8; j++) v[j*64 +: 64] = dbl(j + 1);
    return v;
  endfunction

  task automatic defaults();
    mask_en = 0; lane_mask = '0; zero_mode = 0; vl_sel = 2'b10; bcast = 0; mem_src = 0;
    emb_rc = 2'b00; glob_rc = 2'b00; legacy = 0; reg_spec = 4'hF;
    old_dst = OLDPAT; src_vec = ramp();
  endtask

  task automatic apply();
    @(negedge clk); in_valid = 1'b1;
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R12 watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [VEC_W-1:0] exp;
    logic [VEC_W-1:0] held;
    rst_n = 1'b0; in_valid = 1'b0;
    defaults();
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 reset dst", dst_out, '0);
    check("R12 reset ctl", {out_valid, ud_fault, flags_out}, '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2 R3 R4 table: same value in all eight lanes
    for (int i = 0; i < N_TBL; i++) begin
      defaults();
      src_vec = {8{TBL[i][99:36]}};
      glob_rc = TBL[i][35:34];
      apply();
      check($sformatf("R2,R3,R4 table %0d value", i), dst_out, {256'b0, {8{TBL[i][33:2]}}});
      check($sformatf("R3,R4,R11 table %0d flags", i), flags_out, TBL[i][1:0]);
    end
    check("R12 out_valid pulse", out_valid, 1'b1);

    // R1 R8: two lanes
    defaults(); vl_sel = 2'b00; apply();
    check("R1,R8 vl128", dst_out, {448'b0, 32'd2, 32'd1});
    // R1: four lanes
    defaults(); vl_sel = 2'b01; apply();
    check("R1,R8 vl256", dst_out, {384'b0, 32'd4, 32'd3, 32'd2, 32'd1});
    // R1: code 11 behaves as eight lanes
    defaults(); vl_sel = 2'b11; apply();
    exp = '0;
    for (int j = 0; j < 8; j++) exp[j*32 +: 32] = 32'(j + 1);
    check("R1,R2 vl code 11", dst_out, exp);

    // R5 merge
    defaults(); mask_en = 1; lane_mask = 8'b1010_0101; apply();
    exp = '0;
    for (int j = 0; j < 8; j++) exp[j*32 +: 32] = lane_mask[j] ? 32'(j + 1) : 32'hC0DE_F00D;
    check("R5 merge", dst_out, exp);
    // R5 zero
    defaults(); mask_en = 1; lane_mask = 8'b1010_0101; zero_mode = 1; apply();
    exp = '0;
    for (int j = 0; j < 8; j++) exp[j*32 +: 32] = lane_mask[j] ? 32'(j + 1) : 32'h0;
    check("R5 zero", dst_out, exp);

    // R5 R11: upper mask bits ignored, flags only from written lanes
    defaults(); vl_sel = 2'b00; mask_en = 1; lane_mask = 8'hFC;
    src_vec[63:0] = D_NAN; src_vec[127:64] = D_2P5; apply();
    check("R5 upper mask ignored", dst_out, {448'b0, 32'hC0DE_F00D, 32'hC0DE_F00D});
    check("R11 no written lane", flags_out, 2'b00);
    lane_mask = 8'h01; apply();
    check("R11 one lane value", dst_out, {448'b0, 32'hC0DE_F00D, 32'h8000_0000});
    check("R11 one lane flags", flags_out, 2'b01);
    mask_en = 0; apply();
    check("R11 both lanes flags", flags_out, 2'b11);

    // R6 memory broadcast
    defaults(); vl_sel = 2'b01; mem_src = 1; bcast = 1; glob_rc = 2'b10;
    src_vec[63:0] = D_2P5; apply();
    check("R6 broadcast", dst_out, {384'b0, {4{32'd3}}});
    // R6 R7: register source at 256 neither broadcasts nor overrides
    mem_src = 0; emb_rc = 2'b11; apply();
    check("R6,R7 reg bcast 256", dst_out, {384'b0, 32'd4, 32'd3, 32'd2, 32'd3});
    // R7 override at 512
    defaults(); src_vec = {8{D_2P5}}; bcast = 1; emb_rc = 2'b10; apply();
    check("R7 override", dst_out, {256'b0, {8{32'd3}}});
    // R7 memory broadcast at 512 uses global mode
    defaults(); bcast = 1; mem_src = 1; emb_rc = 2'b10; src_vec[63:0] = D_2P5; apply();
    check("R7,R6 mem bcast global", dst_out, {256'b0, {8{32'd2}}});

    // R9 legacy: mask and override ignored
    defaults(); legacy = 1; mask_en = 1; lane_mask = 8'h00; zero_mode = 1;
    bcast = 1; emb_rc = 2'b10; src_vec = {8{D_2P5}}; apply();
    check("R9,R1 legacy", dst_out, {OLDPAT[511:128], 64'b0, 32'd2, 32'd2});

    // R10 fault
    defaults(); reg_spec = 4'hE; src_vec[63:0] = D_NAN; apply();
    check("R10 fault dst", dst_out, OLDPAT);
    check("R10 fault flags", {ud_fault, flags_out}, 3'b100);
    reg_spec = 4'hF; apply();
    check("R10 fault clears", ud_fault, 1'b0);

    // R12 hold without in_valid
    held = dst_out;
    defaults(); src_vec = {8{D_NAN}}; vl_sel = 2'b00;
    repeat (2) @(negedge clk);
    check("R12 hold dst", dst_out, held);
    check("R12 no valid", out_valid, 1'b0);

    // R12 reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    check("R12 reset clears", dst_out, '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    finish_run();
  end

endmodule